// File: doc/BRIEF.md
# PWM Dimming Gate with Loss-of-Signal Shutdown

This block sits between the LED current programming logic and the main-group current sinks. It takes an asynchronous PWM dimming pin and produces a cycle-by-cycle current-on gate for the main LED group. While the gate is on, the programmed 6-bit main current code is applied; while it is off, the code is forced to zero. Averaged over time, the main current is therefore the code multiplied by the PWM duty cycle. The sub LED group never sees the gate. Its code is registered once and passed through untouched.

The pin is resynchronised by two flops. It is then width-qualified: a level change is accepted only once it has held for a minimum number of clock cycles, so short glitches never reach the gate. A monitor watches the qualified level. If the level stays low longer than the longest legal low time, the monitor drops the valid flag and starts a shutdown timer. When that timer expires, it raises a shutdown request and holds the main gate off. Any qualified rising edge cancels both and restores gating.

When PWM dimming is not enabled, the main group runs at its full programmed code whenever the group is enabled. All widths and delays are parameters counted in clock cycles. The defaults match a 250 MHz clock: 0.5 µs minimum width, 500 µs maximum low time and a 16 ms shutdown delay.

Top module: `pwm_dim_gate`

## Requirements
- R1: While reset is asserted and in the first cycle after it, with the main group disabled: main_gate, pwm_valid and shdn_req are 0, and main_level and sub_level are 0.
- R2: With pwm_en low and main_en high, main_gate is 1 and main_level equals main_code, whatever pwm_in does.
- R3: With main_en low, main_gate is 0 and main_level is 0 in every state.
- R4: With pwm_en and main_en high and the monitor active, main_gate follows the qualified PWM level. Over any whole number of PWM periods, the count of gated cycles equals the count of high input cycles, and the sum of main_level equals main_code times that count.
- R5: pwm_in passes through a two-flop synchronizer. A change in its level is accepted only after the synchronized value has differed from the accepted level for MIN_WIDTH_CYC consecutive cycles. Shorter pulses of either polarity leave main_gate unchanged, and a pulse of exactly MIN_WIDTH_CYC cycles is accepted.
- R6: pwm_valid is 1 while pwm_en is high and the accepted level has not stayed low for MAX_LOW_CYC cycles. It falls once that limit is reached.
- R7: Once pwm_valid has fallen, a further SHDN_CYC cycles of low level raise shdn_req, and main_gate is then held at 0. shdn_req and pwm_valid are never both 1.
- R8: An accepted rising edge during the lost or shutdown condition clears shdn_req, sets pwm_valid again and re-enables gating.
- R9: sub_level equals sub_code one cycle after sub_en is sampled high, and 0 one cycle after it is sampled low, regardless of pwm_in, pwm_en or the shutdown state.
- R10: Lowering pwm_en clears pwm_valid and shdn_req at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwm_in | input | 1 | Raw asynchronous PWM dimming pin |
| pwm_en | input | 1 | PWM dimming enable for the main group |
| main_en | input | 1 | Main LED group on |
| main_code | input | 6 | Programmed main-group current code |
| sub_en | input | 1 | Sub LED group on |
| sub_code | input | 6 | Programmed sub-group current code |
| main_gate | output | 1 | Current-on gate for the main group this cycle |
| main_level | output | 6 | Main current code applied this cycle (0 when gated off) |
| pwm_valid | output | 1 | PWM signal present and within the legal low time |
| shdn_req | output | 1 | Shutdown request after loss of PWM |
| sub_level | output | 6 | Sub-group code, registered, never gated |

## Verification
The main function is driven with random square waves whose high and low times vary independently between the minimum width and just under the loss limit, each with a random current code. Counting gated cycles and summing the level over whole periods separates a correct duty scaling from a gate that is stretched, clipped or carries the wrong code. Directed glitches just below the minimum width, and a pulse exactly at it, separate glitch filtering from an off-by-one in the width qualifier. A long low hold with samples taken on both sides of each threshold locates the valid drop and the shutdown request, and a following rising edge shows the recovery. The bypass, main-off, sub pass-through and disable cases are each applied while the dimming path is in an active state, so any leakage of that state shows at the outputs.

// File: rtl/pwmgate_pkg.sv
package pwmgate_pkg;
  typedef enum logic [1:0] {
    MON_IDLE   = 2'd0,
    MON_ACTIVE = 2'd1,
    MON_LOST   = 2'd2,
    MON_OFF    = 2'd3
  } mon_state_t;
endpackage

// File: rtl/pwm_qualifier.sv
// Two-flop resynchroniser followed by a minimum-width level qualifier.
module pwm_qualifier #(
  parameter int MIN_WIDTH_CYC = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_in,
  output logic level_q,
  output logic rise_q
);
  localparam int CW = (MIN_WIDTH_CYC < 2) ? 1 : $clog2(MIN_WIDTH_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(MIN_WIDTH_CYC - 1);

  logic          meta_q, sync_q;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q  <= 1'b0;
      sync_q  <= 1'b0;
      run_q   <= '0;
      level_q <= 1'b0;
      rise_q  <= 1'b0;
    end else begin
      meta_q <= raw_in;
      sync_q <= meta_q;
      rise_q <= 1'b0;
      if (sync_q != level_q) begin
        if (run_q == LAST) begin
          level_q <= sync_q;
          rise_q  <= sync_q;
          run_q   <= '0;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end else begin
        run_q <= '0;
      end
    end
  end
endmodule

// File: rtl/loss_monitor.sv
// Tracks the qualified PWM level: active, lost (low too long), shut down.
module loss_monitor
  import pwmgate_pkg::*;
#(
  parameter int MAX_LOW_CYC = 125000,
  parameter int SHDN_CYC    = 4000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       level,
  input  logic       rise,
  output mon_state_t state_q
);
  localparam int TMAX = (MAX_LOW_CYC > SHDN_CYC) ? MAX_LOW_CYC : SHDN_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [TW-1:0] LOW_LAST  = TW'(MAX_LOW_CYC - 1);
  localparam logic [TW-1:0] SHDN_LAST = TW'(SHDN_CYC - 1);

  logic [TW-1:0] tmr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= MON_IDLE;
      tmr_q   <= '0;
    end else if (!enable) begin
      state_q <= MON_IDLE;
      tmr_q   <= '0;
    end else begin
      unique case (state_q)
        MON_IDLE: begin
          state_q <= MON_ACTIVE;
          tmr_q   <= '0;
        end
        MON_ACTIVE: begin
          if (level) begin
            tmr_q <= '0;
          end else if (tmr_q == LOW_LAST) begin
            state_q <= MON_LOST;
            tmr_q   <= '0;
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        MON_LOST: begin
          if (rise) begin
            state_q <= MON_ACTIVE;
            tmr_q   <= '0;
          end else if (tmr_q == SHDN_LAST) begin
            state_q <= MON_OFF;
            tmr_q   <= '0;
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        MON_OFF: begin
          tmr_q <= '0;
          if (rise) state_q <= MON_ACTIVE;
        end
        default: begin
          state_q <= MON_IDLE;
          tmr_q   <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/pwm_dim_gate.sv
module pwm_dim_gate
  import pwmgate_pkg::*;
#(
  parameter int CODE_W        = 6,
  parameter int MIN_WIDTH_CYC = 125,
  parameter int MAX_LOW_CYC   = 125000,
  parameter int SHDN_CYC      = 4000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwm_in,
  input  logic              pwm_en,
  input  logic              main_en,
  input  logic [CODE_W-1:0] main_code,
  input  logic              sub_en,
  input  logic [CODE_W-1:0] sub_code,
  output logic              main_gate,
  output logic [CODE_W-1:0] main_level,
  output logic              pwm_valid,
  output logic              shdn_req,
  output logic [CODE_W-1:0] sub_level
);
  logic       qual_level, qual_rise;
  mon_state_t mon_state;

  pwm_qualifier #(.MIN_WIDTH_CYC(MIN_WIDTH_CYC)) qual_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .raw_in  (pwm_in),
    .level_q (qual_level),
    .rise_q  (qual_rise)
  );

  loss_monitor #(.MAX_LOW_CYC(MAX_LOW_CYC), .SHDN_CYC(SHDN_CYC)) mon_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (pwm_en),
    .level   (qual_level),
    .rise    (qual_rise),
    .state_q (mon_state)
  );

  always_comb begin
    if (!main_en)                main_gate = 1'b0;
    else if (!pwm_en)            main_gate = 1'b1;
    else if (mon_state == MON_OFF) main_gate = 1'b0;
    else                         main_gate = qual_level;
  end

  assign main_level = main_gate ? main_code : '0;
  assign pwm_valid  = (mon_state == MON_ACTIVE);
  assign shdn_req   = (mon_state == MON_OFF);

  always_ff @(posedge clk) begin
    if (!rst_n)      sub_level <= '0;
    else if (sub_en) sub_level <= sub_code;
    else             sub_level <= '0;
  end
endmodule

// File: rtl/pwm_dim_gate_chk.sv
module pwm_dim_gate_chk #(
  parameter int CODE_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pwm_en,
  input logic              main_en,
  input logic [CODE_W-1:0] main_code,
  input logic              sub_en,
  input logic [CODE_W-1:0] sub_code,
  input logic              main_gate,
  input logic [CODE_W-1:0] main_level,
  input logic              pwm_valid,
  input logic              shdn_req,
  input logic [CODE_W-1:0] sub_level
);
  // R7
  shdn_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shdn_req |-> !pwm_valid);
  // R3
  main_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !main_en |-> (!main_gate && main_level == '0));
  // R2
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwm_en && main_en) |-> main_gate);
  // R4
  level_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    main_gate |-> (main_level == main_code));
  // R9
  sub_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sub_en |=> (sub_level == '0));
  // R9
  sub_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sub_en |=> (sub_level == $past(sub_code)));
  // R10
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_en |=> (!pwm_valid && !shdn_req));
  // R8
  recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(shdn_req) && pwm_en) |-> pwm_valid);
endmodule

bind pwm_dim_gate pwm_dim_gate_chk #(.CODE_W(CODE_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .pwm_en     (pwm_en),
  .main_en    (main_en),
  .main_code  (main_code),
  .sub_en     (sub_en),
  .sub_code   (sub_code),
  .main_gate  (main_gate),
  .main_level (main_level),
  .pwm_valid  (pwm_valid),
  .shdn_req   (shdn_req),
  .sub_level  (sub_level)
);

// File: tb/pwm_dim_gate_tb_top.sv
module pwm_dim_gate_tb_top;
  localparam int MIN_W = 4;
  localparam int MAX_L = 40;
  localparam int SHD   = 100;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwm_in = 1'b0, pwm_en = 1'b0, main_en = 1'b0, sub_en = 1'b0;
  logic [5:0] main_code = '0, sub_code = '0;
  logic       main_gate, pwm_valid, shdn_req;
  logic [5:0] main_level, sub_level;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  pwm_dim_gate #(.CODE_W(6), .MIN_WIDTH_CYC(MIN_W), .MAX_LOW_CYC(MAX_L),
                 .SHDN_CYC(SHD)) dut_i (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .pwm_en(pwm_en),
    .main_en(main_en), .main_code(main_code), .sub_en(sub_en),
    .sub_code(sub_code), .main_gate(main_gate), .main_level(main_level),
    .pwm_valid(pwm_valid), .shdn_req(shdn_req), .sub_level(sub_level)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Expected sums over whole periods, from R4.
  function automatic int exp_gated(input int h, input int n);
    return h * n;
  endfunction
  function automatic int exp_level_sum(input int code, input int h, input int n);
    return code * h * n;
  endfunction

  // One PWM period; optionally accumulate gate and level samples.
  task automatic period(input int h, input int l, input bit meas,
                        inout int gsum, inout int lsum);
    for (int i = 0; i < h + l; i++) begin
      @(negedge clk);
      if (meas) begin
        gsum += int'(main_gate);
        lsum += int'(main_level);
      end
      pwm_in = (i < h);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int gs, ls, changes;
    logic prev;
    void'($urandom(32'd5150));

    // R1: reset state
    tick(4);
    chk("R1 gate in reset", main_gate, 0);
    chk("R1 valid in reset", pwm_valid, 0);
    chk("R1 shdn in reset", shdn_req, 0);
    rst_n = 1'b1;
    tick(1);
    chk("R1 level after reset", main_level, 0);
    chk("R1 sub after reset", sub_level, 0);

    // R2: bypass with PWM toggling
    main_en = 1'b1; main_code = 6'd45;
    for (int i = 0; i < 20; i++) begin
      pwm_in = i[1];
      tick(1);
      if (i % 5 == 4) begin
        chk("R2 bypass gate", main_gate, 1);
        chk("R2 bypass level", main_level, 45);
      end
    end

    // R4: random duty cycles and codes
    pwm_en = 1'b1;
    pwm_in = 1'b0;
    tick(3);
    chk("R6 valid after enable", pwm_valid, 1);
    for (int it = 0; it < 12; it++) begin
      int h, l, code;
      h = MIN_W + int'($urandom_range(0, 26));
      l = MIN_W + int'($urandom_range(0, 26));
      code = 1 + int'($urandom_range(0, 62));
      main_code = 6'(code);
      gs = 0; ls = 0;
      for (int p = 0; p < 3; p++) period(h, l, 1'b0, gs, ls);
      for (int p = 0; p < 5; p++) period(h, l, 1'b1, gs, ls);
      chk("R4 gated cycles", gs, exp_gated(h, 5));
      chk("R4 level sum", ls, exp_level_sum(code, h, 5));
      chk("R6 valid during pwm", pwm_valid, 1);
    end

    // R5: short low glitch on steady high is ignored
    pwm_in = 1'b1; tick(20);
    chk("R5 gate settled high", main_gate, 1);
    changes = 0; prev = main_gate;
    pwm_in = 1'b0; tick(MIN_W - 1); pwm_in = 1'b1;
    for (int i = 0; i < 15; i++) begin
      tick(1);
      if (main_gate != prev) changes++;
      prev = main_gate;
    end
    chk("R5 low glitch ignored", changes, 0);
    // R5: short high glitch on steady low is ignored
    pwm_in = 1'b0; tick(12);
    chk("R5 gate settled low", main_gate, 0);
    changes = 0; prev = main_gate;
    pwm_in = 1'b1; tick(MIN_W - 1); pwm_in = 1'b0;
    for (int i = 0; i < 12; i++) begin
      tick(1);
      if (main_gate != prev) changes++;
      prev = main_gate;
    end
    chk("R5 high glitch ignored", changes, 0);
    // R5: pulse exactly MIN_W cycles is accepted
    gs = 0;
    pwm_in = 1'b1; tick(MIN_W); pwm_in = 1'b0;
    for (int i = 0; i < 12; i++) begin
      tick(1);
      gs += int'(main_gate);
    end
    chk("R5 min width pulse gated cycles", gs, MIN_W);

    // R6/R7: loss of PWM
    pwm_in = 1'b1; tick(10);
    pwm_in = 1'b0;
    tick(MAX_L);
    chk("R6 valid before low limit", pwm_valid, 1);
    tick(10);
    chk("R6 valid cleared after low limit", pwm_valid, 0);
    chk("R7 no shdn yet", shdn_req, 0);
    tick(SHD - 10);
    chk("R7 shdn not before delay", shdn_req, 0);
    tick(12);
    chk("R7 shdn after delay", shdn_req, 1);
    chk("R7 gate off in shdn", main_gate, 0);
    chk("R7 valid off in shdn", pwm_valid, 0);

    // R9: sub group passes through during shutdown
    sub_en = 1'b1; sub_code = 6'd27;
    tick(1);
    chk("R9 sub level in shdn", sub_level, 27);
    sub_code = 6'd63; tick(1);
    chk("R9 sub follows code", sub_level, 63);
    sub_en = 1'b0; tick(1);
    chk("R9 sub off", sub_level, 0);

    // R3: main group disabled during shutdown and active states
    main_en = 1'b0; tick(1);
    chk("R3 gate off", main_gate, 0);
    chk("R3 level off", main_level, 0);

    // R8: rising edge recovers
    main_en = 1'b1; main_code = 6'd12;
    pwm_in = 1'b1; tick(10);
    chk("R8 shdn cleared", shdn_req, 0);
    chk("R8 valid restored", pwm_valid, 1);
    chk("R8 gate restored", main_gate, 1);
    chk("R8 level restored", main_level, 12);

    // R10: disabling from shutdown
    pwm_in = 1'b0; tick(MAX_L + SHD + 20);
    chk("R10 reached shdn", shdn_req, 1);
    pwm_en = 1'b0; tick(1);
    chk("R10 shdn cleared", shdn_req, 0);
    chk("R10 valid cleared", pwm_valid, 0);
    chk("R2 bypass after disable", main_gate, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule